// File: doc/BRIEF.md
# Bridge Channel Packet Status Register

This block keeps the 16-bit read-only status word for one isochronous bridge channel of a serial-bus controller. Two busy bits show whether the channel is transmitting and whether it is receiving. The start and end command pulses drive these bits, and when both commands arrive in the same cycle the end command wins. The block also watches the header fields of each received isochronous packet, which arrive in parallel with a valid strobe. From these it raises sticky flags for three events: the first packet after receive starts, a change in the copy-control field, and a change in the odd/even key field.

Error pulses from the surrounding receive and transmit logic are also held as sticky bits. The FIFO empty and full levels appear in the word unregistered. Software reads the word through a simple read strobe. The word is returned combinationally in the strobe cycle. Every sticky bit clears on the clock edge that ends that cycle, except a bit whose event arrives in that same cycle.

Top module: `bch_status_reg`

## Requirements
- R1: After reset, every registered bit of `rd_data` reads 0: bits 15..8, 4, 2, 1 and 0.
- R2: Bit 15 (transmit busy) becomes 1 on the edge after `tx_start` and becomes 0 on the edge after `tx_end`. When both are high in the same cycle, the bit becomes 0.
- R3: Bit 14 (receive busy) becomes 1 on the edge after `rx_start` and becomes 0 on the edge after `rx_end`. When both are high in the same cycle, the bit becomes 0.
- R4: A packet is accepted when `pkt_valid` is high in a cycle where bit 14 already reads 1. Bit 13 is set by the first accepted packet after a receive start. Later accepted packets do not set it.
- R5: Bit 12 is set when an accepted packet's `pkt_cpc` differs from the value in the previous accepted packet. The first packet after a receive start is never compared, so it cannot set bit 12.
- R6: Bit 11 follows the R5 rule, but for `pkt_oe`.
- R7: Each error pulse sets one sticky bit on the next edge:
  - `err_dlen` sets bit 10.
  - `err_txlate` sets bit 9.
  - `err_rxlate` sets bit 8.
  - `err_stype` sets bit 4.
  - `err_blkcnt` sets bit 2.
  - `err_hdr` sets bit 1.
  - `err_fmt` sets bit 0.
  
  No pulse affects any other bit.
- R8: `rd_data` shows the current contents in the cycle `rd_en` is high. Sticky bits 13..8, 4 and 2..0 clear on the edge that ends that cycle. A bit whose set event arrives in the read cycle stays 1.
- R9: Bit 5 equals `fifo_empty` and bit 3 equals `fifo_full` in the same cycle. Bits 7 and 6 always read 0.
- R10: A `pkt_valid` while bit 14 reads 0 sets none of bits 13, 12 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_start | input | 1 | Transmit-start command pulse |
| tx_end | input | 1 | Transmit-end command pulse |
| rx_start | input | 1 | Receive-start command pulse |
| rx_end | input | 1 | Receive-end command pulse |
| pkt_valid | input | 1 | Received packet header strobe |
| pkt_cpc | input | CPC_W | Copy-control field of the header |
| pkt_oe | input | OE_W | Odd/even key field of the header |
| err_dlen | input | 1 | Data-length error pulse |
| err_txlate | input | 1 | Transmit late pulse |
| err_rxlate | input | 1 | Receive late pulse |
| err_stype | input | 1 | Stream-type error pulse |
| err_blkcnt | input | 1 | Block-count error pulse |
| err_hdr | input | 1 | Packet header error pulse |
| err_fmt | input | 1 | Format error pulse |
| fifo_empty | input | 1 | FIFO empty level |
| fifo_full | input | 1 | FIFO full level |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Status word |

## Verification
A stale previous-field register would show up as a wrong bit 12 or 11 on the first read after the second accepted packet. An armed first-packet state that never clears would show up as bit 13 coming back after a read and a further packet. The bench sweeps every pair of copy-control values and both odd/even pairs, and every start/end combination from both busy states. It also pulses each error input alone and together with a read, so that a wrong clear-on-read appears within one cycle of the strobe.

// File: rtl/bch_status_pkg.sv
package bch_status_pkg;
   localparam int WORD_W = 16;
   localparam int ERR_N  = 7;
   // positions of the sticky error bits, index order of the error vector
   localparam int ERR_POS [ERR_N] = '{10, 9, 8, 4, 2, 1, 0};
   localparam int POS_TXB   = 15;
   localparam int POS_RXB   = 14;
   localparam int POS_FIRST = 13;
   localparam int POS_CPC   = 12;
   localparam int POS_OE    = 11;
   localparam int POS_EMPTY = 5;
   localparam int POS_FULL  = 3;
   typedef enum logic [0:0] {CH_TX = 1'b0, CH_RX = 1'b1} chan_e;
endpackage

// File: rtl/bch_run_flag.sv
module bch_run_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic end_i,
   output logic busy_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       busy_o <= 1'b0;
      else if (end_i)   busy_o <= 1'b0;
      else if (start_i) busy_o <= 1'b1;
   end
endmodule

// File: rtl/bch_field_track.sv
module bch_field_track #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         accept_i,
   input  logic         first_i,
   input  logic [W-1:0] field_i,
   output logic         chg_o
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        prev_q <= '0;
      else if (accept_i) prev_q <= field_i;
   end

   assign chg_o = accept_i && !first_i && (field_i != prev_q);
endmodule

// File: rtl/bch_sticky_bank.sv
module bch_sticky_bank #(
   parameter int N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic [N-1:0] set_i,
   output logic [N-1:0] q_o
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_o[i] <= 1'b0;
         else        q_o[i] <= set_i[i] | (q_o[i] & ~clr_i);
      end
   end
endmodule

// File: rtl/bch_status_reg.sv
module bch_status_reg
   import bch_status_pkg::*;
#(
   parameter int CPC_W = 2,
   parameter int OE_W  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_start,
   input  logic              tx_end,
   input  logic              rx_start,
   input  logic              rx_end,
   input  logic              pkt_valid,
   input  logic [CPC_W-1:0]  pkt_cpc,
   input  logic [OE_W-1:0]   pkt_oe,
   input  logic              err_dlen,
   input  logic              err_txlate,
   input  logic              err_rxlate,
   input  logic              err_stype,
   input  logic              err_blkcnt,
   input  logic              err_hdr,
   input  logic              err_fmt,
   input  logic              fifo_empty,
   input  logic              fifo_full,
   input  logic              rd_en,
   output logic [WORD_W-1:0] rd_data
);
   localparam int EV_N = 3;

   if (CPC_W < 1 || CPC_W > 8) begin : g_bad_cpc
      $error("CPC_W out of range");
   end
   if (OE_W < 1 || OE_W > 8) begin : g_bad_oe
      $error("OE_W out of range");
   end

   logic [1:0] cmd_start, cmd_end, busy;
   assign cmd_start = {rx_start, tx_start};
   assign cmd_end   = {rx_end, tx_end};

   for (genvar c = 0; c < 2; c++) begin : g_chan
      bch_run_flag u_run (
         .clk(clk), .rst_n(rst_n),
         .start_i(cmd_start[c]), .end_i(cmd_end[c]), .busy_o(busy[c])
      );
   end

   logic accept, armed_q;
   assign accept = pkt_valid & busy[CH_RX];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    armed_q <= 1'b0;
      else if (rx_start && !rx_end)  armed_q <= 1'b1;
      else if (accept)               armed_q <= 1'b0;
   end

   logic cpc_chg, oe_chg;
   bch_field_track #(.W(CPC_W)) u_cpc (
      .clk(clk), .rst_n(rst_n), .accept_i(accept), .first_i(armed_q),
      .field_i(pkt_cpc), .chg_o(cpc_chg)
   );
   bch_field_track #(.W(OE_W)) u_oe (
      .clk(clk), .rst_n(rst_n), .accept_i(accept), .first_i(armed_q),
      .field_i(pkt_oe), .chg_o(oe_chg)
   );

   logic [EV_N-1:0] ev_set, ev_q;
   assign ev_set = {accept & armed_q, cpc_chg, oe_chg};
   bch_sticky_bank #(.N(EV_N)) u_ev (
      .clk(clk), .rst_n(rst_n), .clr_i(rd_en), .set_i(ev_set), .q_o(ev_q)
   );

   logic [ERR_N-1:0] err_set, err_q;
   assign err_set = {err_fmt, err_hdr, err_blkcnt, err_stype,
                     err_rxlate, err_txlate, err_dlen};
   bch_sticky_bank #(.N(ERR_N)) u_err (
      .clk(clk), .rst_n(rst_n), .clr_i(rd_en), .set_i(err_set), .q_o(err_q)
   );

   always_comb begin
      rd_data            = '0;
      rd_data[POS_TXB]   = busy[CH_TX];
      rd_data[POS_RXB]   = busy[CH_RX];
      rd_data[POS_FIRST] = ev_q[2];
      rd_data[POS_CPC]   = ev_q[1];
      rd_data[POS_OE]    = ev_q[0];
      rd_data[POS_EMPTY] = fifo_empty;
      rd_data[POS_FULL]  = fifo_full;
      for (int k = 0; k < ERR_N; k++) rd_data[ERR_POS[k]] = err_q[k];
   end
endmodule

// File: rtl/bch_status_chk.sv
module bch_status_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        tx_start,
   input logic        tx_end,
   input logic        rx_start,
   input logic        rx_end,
   input logic        pkt_valid,
   input logic        err_fmt,
   input logic        err_dlen,
   input logic        rd_en,
   input logic [15:0] rd_data
);
   // R2
   tx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start && !tx_end |=> rd_data[15]);
   // R2
   tx_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_end |=> !rd_data[15]);
   // R3
   rx_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_end |=> !rd_data[14]);
   // R3
   rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_start && !rx_end |=> $stable(rd_data[14]));
   // R10
   idle_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[14] && !rd_data[13] |=> !rd_data[13]);
   // R8
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !pkt_valid |=> !rd_data[13] && !rd_data[12] && !rd_data[11]);
   // R7
   fmt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_fmt |=> rd_data[0]);
   // R8
   dlen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[10] && !rd_en |=> rd_data[10]);
   // R8
   dlen_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !err_dlen |=> !rd_data[10]);
endmodule

bind bch_status_reg bch_status_chk u_chk (
   .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_end(tx_end),
   .rx_start(rx_start), .rx_end(rx_end), .pkt_valid(pkt_valid),
   .err_fmt(err_fmt), .err_dlen(err_dlen), .rd_en(rd_en), .rd_data(rd_data)
);

// File: tb/tb_bch_status_reg.sv
`timescale 1ns/1ps
module tb_bch_status_reg;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_start = 0, tx_end = 0, rx_start = 0, rx_end = 0, pkt_valid = 0;
   logic [1:0] pkt_cpc = '0;
   logic [0:0] pkt_oe = '0;
   logic [6:0] errs = '0;   // {fmt,hdr,blkcnt,stype,rxlate,txlate,dlen}
   logic fifo_empty = 0, fifo_full = 0, rd_en = 0;
   logic [15:0] rd_data;
   int n_chk = 0, n_fail = 0;
   int epos [7] = '{10, 9, 8, 4, 2, 1, 0};

   always #5 clk = ~clk;

   bch_status_reg dut (
      .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_end(tx_end),
      .rx_start(rx_start), .rx_end(rx_end), .pkt_valid(pkt_valid),
      .pkt_cpc(pkt_cpc), .pkt_oe(pkt_oe),
      .err_dlen(errs[0]), .err_txlate(errs[1]), .err_rxlate(errs[2]),
      .err_stype(errs[3]), .err_blkcnt(errs[4]), .err_hdr(errs[5]),
      .err_fmt(errs[6]), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
      .rd_en(rd_en), .rd_data(rd_data)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one clock, then drop all pulses; rd_data is sampled 1 ns after the edge
   task automatic tick();
      @(posedge clk); #1;
      tx_start = 0; tx_end = 0; rx_start = 0; rx_end = 0;
      pkt_valid = 0; errs = '0; rd_en = 0;
   endtask

   task automatic do_read();
      rd_en = 1; tick();
   endtask

   task automatic send(input logic [1:0] c, input logic [0:0] o);
      pkt_valid = 1; pkt_cpc = c; pkt_oe = o; tick();
   endtask

   initial begin
      #1500000;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      chk("R1 reset word", rd_data, 16'h0000);

      // R9 live FIFO bits, reserved bits 7..6
      for (int f = 0; f < 4; f++) begin
         fifo_empty = f[0]; fifo_full = f[1]; #1;
         chk("R9 fifo live", rd_data & 16'h00E8, {8'h00, 2'b00, f[0], 1'b0, f[1], 3'b000});
      end
      fifo_empty = 0; fifo_full = 0;

      // R2 / R3 all start/end combinations from both busy states
      for (int ch = 0; ch < 2; ch++)
         for (int st = 0; st < 2; st++)
            for (int c = 0; c < 4; c++) begin
               logic e;
               if (ch == 0) begin tx_start = st[0]; tx_end = !st[0]; end
               else begin rx_start = st[0]; rx_end = !st[0]; end
               tick();
               if (ch == 0) begin tx_start = c[0]; tx_end = c[1]; end
               else begin rx_start = c[0]; rx_end = c[1]; end
               e = c[1] ? 1'b0 : (c[0] ? 1'b1 : st[0]);
               tick();
               if (ch == 0) chk("R2 tx busy", {15'd0, rd_data[15]}, {15'd0, e});
               else         chk("R3 rx busy", {15'd0, rd_data[14]}, {15'd0, e});
            end
      rx_end = 1; tx_end = 1; tick(); do_read();

      // R10 packets while idle are ignored
      send(2'd3, 1'b1); send(2'd0, 1'b0);
      chk("R10 idle packets", rd_data & 16'h3800, 16'h0000);

      // R4 R5 R6 sweep of field pairs
      for (int a = 0; a < 8; a++)
         for (int b = 0; b < 8; b++) begin
            logic [15:0] exp;
            rx_start = 1; tick();
            send(a[1:0], a[2]);
            exp = 16'h6000;  // busy + first
            chk("R4 first packet only", rd_data & 16'h7800, exp);
            do_read();
            send(b[1:0], b[2]);
            exp = 16'h4000;
            if (a[1:0] != b[1:0]) exp[12] = 1;
            if (a[2] != b[2])     exp[11] = 1;
            chk("R5 R6 field change", rd_data & 16'h7800, exp);
            do_read();
            chk("R8 cleared", rd_data & 16'h3800, 16'h0000);
            rx_end = 1; tick();
         end

      // R5 first packet after restart not compared with stale field
      rx_start = 1; tick(); send(2'd1, 1'b0); do_read();
      rx_end = 1; tick(); rx_start = 1; tick();
      send(2'd2, 1'b1);
      chk("R5 no stale compare", rd_data & 16'h3800, 16'h2000);
      send(2'd2, 1'b1);
      do_read();
      chk("R4 later packet no set", rd_data & 16'h3800, 16'h0000);

      // R8 event in read cycle is kept
      rd_en = 1; pkt_valid = 1; pkt_cpc = 2'd0; pkt_oe = 1'b0; tick();
      chk("R8 chg kept on read", rd_data & 16'h1800, 16'h1800);
      do_read();
      rx_end = 1; tick();

      // R7 each error pulse alone, R8 clear and same-cycle hold
      for (int k = 0; k < 7; k++) begin
         logic [15:0] m;
         m = 16'h0; m[epos[k]] = 1;
         errs[k] = 1; tick();
         chk("R7 error bit map", rd_data, m);
         rd_en = 1; #1;
         chk("R8 read shows contents", rd_data, m);
         tick();
         chk("R8 clear after read", rd_data, 16'h0000);
         errs[k] = 1; rd_en = 1; tick();
         chk("R8 set wins over read", rd_data, m);
         do_read();
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule